// File: doc/BRIEF.md
# Boost Regulator Startup and Fault Sequencer

This block is the digital supervisor of a synchronous boost regulator. It steps the regulator from shutdown to regulation, using comparator flags from the analog side. First comes a linear precharge of the output from the input, in two current stages. Then a soft start with switching enabled and the current limit at half of nominal. From soft start the block goes to either normal boost operation or a pass-through bypass, depending on the input level. Each phase has its own timeout. An expired timeout, a sustained current-limit condition or a bypass switch trip moves the block to a fault hold-off. After the hold-off it restarts the precharge on its own.

Every interval is counted in microseconds. A divider makes the microsecond tick from the clock, and the divider restarts on every state entry. A timed interval of N microseconds therefore lasts exactly N·CLK_PER_US clock cycles from the entry edge. A single parameter picks the fast or slow startup variant. The fast variant doubles the precharge current codes and halves the interval between soft-start reference steps.

All inputs and outputs are plain control and status levels; no data stream passes through the block. The outputs decode the state register, except for the reference step strobe. That strobe is a one-cycle pulse that follows the divider tick.

Top module: `boost_seq_top`

## Requirements
- R1: With rst_n low, or in the cycle after en is sampled low from any state, the state code is 0 (shutdown). In shutdown, ilin_sel, sw_en, half_ilim, ref_step, byp_en and fault are all 0.
- R2: In shutdown, if en and uvlo_ok are both sampled high, the next state is 1 (first precharge stage). Any other input combination keeps the state at 0.
- R3: In state 1, ilin_sel is 1 (2 when FAST=1). If vout_near_vin is sampled high, the next state is 3 (soft start). Otherwise the block moves to state 2 exactly LIN1_US·CLK_PER_US cycles after entering state 1.
- R4: In state 2, ilin_sel is 2 (4 when FAST=1). If vout_near_vin is sampled high, the next state is 3. Otherwise the block moves to state 6 (fault) exactly LIN2_US·CLK_PER_US cycles after entering state 2.
- R5: In state 3, sw_en=1 and half_ilim=1. ref_step pulses for one cycle at the end of every SS_STEP_US microseconds after entry (every SS_STEP_US/2 microseconds, at least 1, when FAST=1). Without vout_at_min, the block moves to state 6 exactly SS_US·CLK_PER_US cycles after entry.
- R6: In state 3, when vout_at_min is sampled high, the next state is 5 (bypass) if vin_above_reg is high, and 4 (boost) otherwise.
- R7: In state 4, sw_en=1 and half_ilim=0. If ilim_act stays high for OVLD_US·CLK_PER_US consecutive cycles, the block moves to state 6. Any cycle with ilim_act low restarts that count.
- R8: In state 5, byp_en=1 and sw_en=0, and ilim_act has no effect. A vds_trip sampled high moves the block to state 6 on the next clock.
- R9: In state 6, fault=1 and sw_en=byp_en=0. Exactly HOLD_US·CLK_PER_US cycles after entry, the block restarts in state 1.
- R10: state_o uses the encoding 0 shutdown, 1 precharge stage 1, 2 precharge stage 2, 3 soft start, 4 boost, 5 bypass, 6 fault. The value 7 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Regulator enable |
| uvlo_ok | input | 1 | Input voltage above undervoltage lockout |
| vout_near_vin | input | 1 | Output within 300 mV of the input |
| vout_at_min | input | 1 | Output has reached the minimum setpoint |
| vin_above_reg | input | 1 | Input above the regulation setpoint |
| ilim_act | input | 1 | Boost current limit active |
| vds_trip | input | 1 | Bypass switch VDS protection tripped |
| state_o | output | 3 | State code (R10) |
| ilin_sel | output | 3 | Precharge current level code |
| sw_en | output | 1 | Switching enable |
| half_ilim | output | 1 | Current limit at half of nominal |
| ref_step | output | 1 | Soft-start reference step strobe |
| byp_en | output | 1 | Bypass pass-device enable |
| fault | output | 1 | Fault hold-off active |

## Verification
The assertions assume that each comparator flag is a synchronous level that stays stable across a clock edge, and that reset is released with en low. The bench changes every input only on the falling clock edge and starts each scenario from shutdown by dropping en. It sweeps all 128 combinations of the seven flags from shutdown. Timed paths are entered with known flag settings and held there, so that each timeout edge lands on a cycle the bench computes from the parameters.

// File: rtl/boost_seq_pkg.sv
package boost_seq_pkg;
  typedef enum logic [2:0] {
    ST_SHDN  = 3'd0,
    ST_LIN1  = 3'd1,
    ST_LIN2  = 3'd2,
    ST_SS    = 3'd3,
    ST_BST   = 3'd4,
    ST_BPS   = 3'd5,
    ST_FAULT = 3'd6
  } seq_state_t;
endpackage

// File: rtl/us_tick_div.sv
module us_tick_div #(
  parameter int CLK_PER_US = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DW-1:0] LAST = DW'(CLK_PER_US - 1);

  logic [DW-1:0] div_q;

  assign tick = (div_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (clr)  div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int CW   = 16,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          expired,
  output logic          step_stb
);
  localparam int SW = (STEP > 1) ? $clog2(STEP) : 1;
  localparam logic [SW-1:0] SLAST = SW'(STEP - 1);

  logic [CW-1:0] cnt_q;
  logic [SW-1:0] scnt_q;

  assign expired  = tick && (cnt_q == limit - 1'b1);
  assign step_stb = tick && (scnt_q == SLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      scnt_q <= '0;
    end else if (clr) begin
      cnt_q  <= '0;
      scnt_q <= '0;
    end else if (tick) begin
      cnt_q  <= expired ? '0 : cnt_q + 1'b1;
      scnt_q <= step_stb ? '0 : scnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import boost_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       uvlo_ok,
  input  logic       vout_near_vin,
  input  logic       vout_at_min,
  input  logic       vin_above_reg,
  input  logic       ilim_act,
  input  logic       vds_trip,
  input  logic       expired,
  output seq_state_t state,
  output seq_state_t nxt
);
  always_comb begin
    nxt = state;
    if (!en) begin
      nxt = ST_SHDN;
    end else begin
      unique case (state)
        ST_SHDN:  if (uvlo_ok) nxt = ST_LIN1;
        ST_LIN1:  if (vout_near_vin) nxt = ST_SS;
                  else if (expired) nxt = ST_LIN2;
        ST_LIN2:  if (vout_near_vin) nxt = ST_SS;
                  else if (expired) nxt = ST_FAULT;
        ST_SS:    if (vout_at_min) nxt = vin_above_reg ? ST_BPS : ST_BST;
                  else if (expired) nxt = ST_FAULT;
        ST_BST:   if (expired && ilim_act) nxt = ST_FAULT;
        ST_BPS:   if (vds_trip) nxt = ST_FAULT;
        ST_FAULT: if (expired) nxt = ST_LIN1;
        default:  nxt = ST_SHDN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_SHDN;
    else        state <= nxt;
  end
endmodule

// File: rtl/boost_seq_top.sv
module boost_seq_top
  import boost_seq_pkg::*;
#(
  parameter int CLK_PER_US = 16,
  parameter int LIN1_US    = 512,
  parameter int LIN2_US    = 1024,
  parameter int SS_US      = 64,
  parameter int OVLD_US    = 2000,
  parameter int HOLD_US    = 20000,
  parameter int SS_STEP_US = 4,
  parameter bit FAST       = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       uvlo_ok,
  input  logic       vout_near_vin,
  input  logic       vout_at_min,
  input  logic       vin_above_reg,
  input  logic       ilim_act,
  input  logic       vds_trip,
  output logic [2:0] state_o,
  output logic [2:0] ilin_sel,
  output logic       sw_en,
  output logic       half_ilim,
  output logic       ref_step,
  output logic       byp_en,
  output logic       fault
);
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXL  = imax(imax(imax(LIN1_US, LIN2_US), imax(SS_US, OVLD_US)), HOLD_US);
  localparam int CW    = $clog2(MAXL + 1);
  localparam int STEP  = FAST ? imax(SS_STEP_US / 2, 1) : SS_STEP_US;
  localparam logic [2:0] ILIN_LO = FAST ? 3'd2 : 3'd1;
  localparam logic [2:0] ILIN_HI = FAST ? 3'd4 : 3'd2;

  seq_state_t    state, nxt;
  logic          tick, expired, step_stb, clr;
  logic [CW-1:0] limit;

  // Restart all timing on each state entry; in boost, a low current-limit
  // flag restarts the overload window.
  assign clr = (nxt != state) || ((state == ST_BST) && !ilim_act);

  always_comb begin
    unique case (state)
      ST_LIN1: limit = CW'(LIN1_US);
      ST_LIN2: limit = CW'(LIN2_US);
      ST_SS:   limit = CW'(SS_US);
      ST_BST:  limit = CW'(OVLD_US);
      default: limit = CW'(HOLD_US);
    endcase
  end

  us_tick_div #(.CLK_PER_US(CLK_PER_US)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick)
  );

  phase_timer #(.CW(CW), .STEP(STEP)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .limit(limit),
    .expired(expired), .step_stb(step_stb)
  );

  seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en), .uvlo_ok(uvlo_ok),
    .vout_near_vin(vout_near_vin), .vout_at_min(vout_at_min),
    .vin_above_reg(vin_above_reg), .ilim_act(ilim_act), .vds_trip(vds_trip),
    .expired(expired), .state(state), .nxt(nxt)
  );

  always_comb begin
    state_o   = state;
    ilin_sel  = (state == ST_LIN1) ? ILIN_LO :
                (state == ST_LIN2) ? ILIN_HI : 3'd0;
    sw_en     = (state == ST_SS) || (state == ST_BST);
    half_ilim = (state == ST_SS);
    ref_step  = (state == ST_SS) && step_stb;
    byp_en    = (state == ST_BPS);
    fault     = (state == ST_FAULT);
  end
endmodule

// File: rtl/boost_seq_chk.sv
module boost_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       uvlo_ok,
  input logic       vout_near_vin,
  input logic       vout_at_min,
  input logic       vin_above_reg,
  input logic       vds_trip,
  input logic [2:0] state_o,
  input logic       sw_en,
  input logic       byp_en,
  input logic       ref_step,
  input logic       fault
);
  // R1
  en_low_shdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state_o == 3'd0));

  // R2
  shdn_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0) && en && uvlo_ok |=> (state_o == 3'd1));

  // R3
  lin1_near_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1) && en && vout_near_vin |=> (state_o == 3'd3));

  // R6
  ss_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3) && en && vout_at_min |=>
      (state_o == ($past(vin_above_reg) ? 3'd5 : 3'd4)));

  // R8
  bps_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5) && en && vds_trip |=> (state_o == 3'd6));

  // R5
  ref_step_ss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_step |-> (state_o == 3'd3));

  // R9
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!sw_en && !byp_en));

  // R10
  state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 3'd7);
endmodule

bind boost_seq_top boost_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .uvlo_ok(uvlo_ok),
  .vout_near_vin(vout_near_vin), .vout_at_min(vout_at_min),
  .vin_above_reg(vin_above_reg), .vds_trip(vds_trip), .state_o(state_o),
  .sw_en(sw_en), .byp_en(byp_en), .ref_step(ref_step), .fault(fault)
);

// File: tb/boost_seq_top_tb.sv
`timescale 1ns/1ps
module boost_seq_top_tb;
  localparam int CLK_P = 10;
  localparam int K     = 2;
  localparam int L1    = 8;
  localparam int L2    = 16;
  localparam int LSS   = 6;
  localparam int LOV   = 10;
  localparam int LH    = 12;
  localparam int STP   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, uvlo_ok = 0, near = 0, at_min = 0, vin_hi = 0, ilim = 0, vds = 0;
  logic [2:0] st, ilin, st_f, ilin_f;
  logic sw, half, rstep, byp, flt;
  logic sw_f, half_f, rstep_f, byp_f, flt_f;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  boost_seq_top #(.CLK_PER_US(K), .LIN1_US(L1), .LIN2_US(L2), .SS_US(LSS),
    .OVLD_US(LOV), .HOLD_US(LH), .SS_STEP_US(STP), .FAST(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .uvlo_ok(uvlo_ok), .vout_near_vin(near),
    .vout_at_min(at_min), .vin_above_reg(vin_hi), .ilim_act(ilim), .vds_trip(vds),
    .state_o(st), .ilin_sel(ilin), .sw_en(sw), .half_ilim(half),
    .ref_step(rstep), .byp_en(byp), .fault(flt));

  boost_seq_top #(.CLK_PER_US(K), .LIN1_US(L1), .LIN2_US(L2), .SS_US(LSS),
    .OVLD_US(LOV), .HOLD_US(LH), .SS_STEP_US(STP), .FAST(1'b1)) u_dut_fast (
    .clk(clk), .rst_n(rst_n), .en(en), .uvlo_ok(uvlo_ok), .vout_near_vin(near),
    .vout_at_min(at_min), .vin_above_reg(vin_hi), .ilim_act(ilim), .vds_trip(vds),
    .state_o(st_f), .ilin_sel(ilin_f), .sw_en(sw_f), .half_ilim(half_f),
    .ref_step(rstep_f), .byp_en(byp_f), .fault(flt_f));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_in(input logic [6:0] v);
    {vds, ilim, vin_hi, at_min, near, uvlo_ok, en} = v;
  endtask

  task automatic go_shdn();
    set_in(7'd0);
    step(1);
    chk("R1 shutdown", st, 0);
  endtask

  task automatic outs_zero(input string req);
    chk(req, {ilin, sw, half, rstep, byp, flt}, 0);
  endtask

  task automatic to_ss();
    en = 1; uvlo_ok = 1; near = 1;
    step(1);
    chk("R2 enter precharge", st, 1);
    step(1);
    chk("R3 near to soft start", st, 3);
    near = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int strobes, strobes_f;
    step(3);
    chk("R1 reset state", st, 0);
    outs_zero("R1 reset outputs");
    rst_n = 1;
    step(1);

    // R2 sweep of every flag combination from shutdown
    for (int v = 0; v < 128; v++) begin
      set_in(7'(v));
      step(1);
      chk("R2 shutdown exit sweep", st, (v[0] && v[1]) ? 1 : 0);
      go_shdn();
      outs_zero("R1 shutdown outputs");
    end

    // R3 / R4 / R9 timed precharge path into fault and restart
    en = 1; uvlo_ok = 1;
    step(1);
    chk("R3 state", st, 1);
    chk("R3 ilin slow", ilin, 1);
    chk("R3 ilin fast", ilin_f, 2);
    step(K*L1 - 1);
    chk("R3 before timeout", st, 1);
    step(1);
    chk("R3 timeout to stage 2", st, 2);
    chk("R4 ilin slow", ilin, 2);
    chk("R4 ilin fast", ilin_f, 4);
    step(K*L2 - 1);
    chk("R4 before timeout", st, 2);
    step(1);
    chk("R4 timeout to fault", st, 6);
    chk("R9 fault flag", flt, 1);
    chk("R9 outputs quiet", {sw, byp}, 0);
    step(K*LH - 1);
    chk("R9 before restart", st, 6);
    step(1);
    chk("R9 restart", st, 1);

    // R5 soft start strobes and timeout
    near = 1;
    step(1);
    near = 0;
    chk("R5 state", st, 3);
    chk("R5 sw_en/half", {sw, half}, 3);
    strobes = 0; strobes_f = 0;
    for (int i = 0; i < K*LSS; i++) begin
      if (i > 0) step(1);
      strobes += rstep;
      strobes_f += rstep_f;
      if (i < K*LSS - 1) chk("R5 still soft start", st, 3);
    end
    chk("R5 step count slow", strobes, LSS / STP);
    chk("R5 step count fast", strobes_f, LSS);
    step(1);
    chk("R5 timeout to fault", st, 6);
    go_shdn();

    // R4 near exit from stage 2
    en = 1; uvlo_ok = 1;
    step(1);
    step(K*L1);
    chk("R4 in stage 2", st, 2);
    near = 1;
    step(1);
    chk("R4 near to soft start", st, 3);
    near = 0;

    // R6 / R7 boost branch and overload window
    at_min = 1;
    step(1);
    at_min = 0;
    chk("R6 to boost", st, 4);
    chk("R7 sw_en/half", {sw, half}, 2);
    ilim = 1;
    step(15);
    ilim = 0;
    step(1);
    chk("R7 short overload ignored", st, 4);
    ilim = 1;
    step(K*LOV - 1);
    chk("R7 before overload fault", st, 4);
    step(1);
    chk("R7 overload fault", st, 6);
    ilim = 0;
    go_shdn();

    // R6 / R8 bypass branch and trip
    to_ss();
    at_min = 1; vin_hi = 1;
    step(1);
    chk("R6 to bypass", st, 5);
    chk("R8 byp_en/sw_en", {byp, sw}, 2);
    ilim = 1;
    step(30);
    chk("R8 ilim ignored in bypass", st, 5);
    vds = 1;
    step(1);
    chk("R8 trip to fault", st, 6);
    go_shdn();

    // R1 enable drop from boost
    to_ss();
    at_min = 1;
    step(1);
    chk("R6 boost again", st, 4);
    en = 0;
    step(1);
    chk("R1 drop from boost", st, 0);
    outs_zero("R1 outputs after drop");
    chk("R10 code range", (st_f <= 3'd6) ? 1 : 0, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule